// File: doc/BRIEF.md
# Keypad Matrix Scanner and Encoder

This block watches a switch matrix of up to 8 rows by 10 columns and turns each qualified key press or key release into a one-byte event for an external event queue. Two enable masks, one for the rows and one for the columns, decide which lines belong to the matrix. While nothing is pressed, the block pulls every enabled column low and waits for an enabled row to fall. A falling row wakes a scan. The scan drives one enabled column at a time and reads the rows. Columns outside the matrix are never driven.

Each full pass over the columns yields a frame of 80 raw key bits. A change in the frame is reported only after the frame has stayed unchanged for a qualification time of `QUAL_TICKS` ticks of `TICK_CYCLES` clock cycles each (25 ms by default). The block then walks the key positions column by column, and row by row within a column. For every key whose raw state differs from the reported state, it pushes an event byte: the key number `row*COLS + col + 1` sits in bits 6:0, and bit 7 is 1 for a press and 0 for a release. Each push sets a sticky key-event status bit. That bit drives the interrupt request only while the interrupt enable is high.

States: `ST_IDLE` (all enabled columns low; wake on an enabled row low goes to `ST_DRIVE`). `ST_DRIVE` (one column driven for a settle cycle; an enabled column goes to `ST_SAMPLE`; a disabled one is skipped, to the next `ST_DRIVE` or, after the last column, to `ST_FRAME`). `ST_SAMPLE` (rows captured; to the next `ST_DRIVE` or, after the last column, to `ST_FRAME`). `ST_FRAME` (a stable, qualified frame that differs from the reported state goes to `ST_EMIT`; an all-open frame with nothing reported goes to `ST_IDLE`; otherwise a new pass starts in `ST_DRIVE`). `ST_EMIT` (one position per cycle; after the last one, to `ST_IDLE` if the frame is all open, otherwise to `ST_DRIVE`).

Top module: `kpd_matrix_scan`

## Requirements
- R1: After reset, no event is pushed, `ke_status` and `irq_req` are 0, and `col_drive_low` equals `col_en`.
- R2: A column whose `col_en` bit is 0 is never driven, so `col_drive_low & ~col_en` is always 0.
- R3: The block wakes only when an enabled row reads low. During a scan at most one column is driven at a time. A key in a disabled row or disabled column produces no event.
- R4: A press or release is pushed only after the frame has stayed stable for at least `QUAL_TICKS*TICK_CYCLES` cycles. A press shorter than that produces no event.
- R5: A press event has bit 7 = 1 and bits 6:0 = `row*COLS + col + 1`, so row 0 / column 0 gives 1 and row 7 / column 9 gives 80.
- R6: When a reported key opens and stays open for the qualification time, exactly one event is pushed with bit 7 = 0 and the same key number in bits 6:0.
- R7: Keys that change together are pushed in scan order: ascending column, then ascending row within a column.
- R8: Each push sets `ke_status` on the next cycle. `status_clr` clears it. `irq_req` is high exactly when `ke_status` and `irq_en` are both 1.
- R9: Once every key is reported released, the block returns to idle with `col_drive_low` equal to `col_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_en | input | ROWS | 1 = row is part of the matrix |
| col_en | input | COLS | 1 = column is part of the matrix |
| row_in | input | ROWS | Row levels, pulled high; low = connected to a driven column |
| col_drive_low | output | COLS | 1 = drive this column low, 0 = leave it released |
| irq_en | input | 1 | Key-event interrupt enable |
| status_clr | input | 1 | Clears the key-event status bit |
| evt_push | output | 1 | One-cycle strobe: `evt_code` is a new event |
| evt_code | output | 8 | Bit 7 press(1)/release(0), bits 6:0 key number |
| ke_status | output | 1 | Sticky key-event status |
| irq_req | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that the row inputs settle within the one-cycle drive window and stay stable while they are sampled. They also assume that the enable masks change only while the block is idle with no key down, and that the event queue accepts every push. The bench models the matrix combinationally: a row reads low exactly when a held key connects it to a column being driven. It changes keys and enables only at falling clock edges, and it rewrites the masks only after the block has returned to idle with every key open.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_SAMPLE,
        ST_FRAME,
        ST_EMIT
    } kpd_state_e;
endpackage

// File: rtl/kpd_qual_timer.sv
module kpd_qual_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt;

    assign done = (cnt == TW'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (!done)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/kpd_col_drive.sv
module kpd_col_drive
    import kpd_pkg::*;
#(
    parameter int COLS = 10,
    localparam int CW = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  kpd_state_e        state,
    input  logic [CW-1:0]     col_idx,
    input  logic [COLS-1:0]   col_en,
    output logic [COLS-1:0]   col_drive_low
);
    logic [COLS-1:0] sel;

    assign sel = COLS'(1) << col_idx;

    always_comb begin
        unique case (state)
            ST_IDLE:             col_drive_low = col_en;
            ST_DRIVE, ST_SAMPLE: col_drive_low = col_en & sel;
            default:             col_drive_low = '0;
        endcase
    end

    AST_SCAN_ONE_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> $onehot0(col_drive_low)); // R3
endmodule

// File: rtl/kpd_irq_status.sv
module kpd_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic status,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    status <= 1'b0;
        else if (set)  status <= 1'b1;
        else if (clr)  status <= 1'b0;
    end

    assign irq = status & en;

    AST_STATUS_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> status); // R8
endmodule

// File: rtl/kpd_matrix_scan.sv
module kpd_matrix_scan
    import kpd_pkg::*;
#(
    parameter int ROWS        = 8,
    parameter int COLS        = 10,
    parameter int TICK_CYCLES = 125000,
    parameter int QUAL_TICKS  = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROWS-1:0]  row_en,
    input  logic [COLS-1:0]  col_en,
    input  logic [ROWS-1:0]  row_in,
    output logic [COLS-1:0]  col_drive_low,
    input  logic             irq_en,
    input  logic             status_clr,
    output logic             evt_push,
    output logic [7:0]       evt_code,
    output logic             ke_status,
    output logic             irq_req
);
    localparam int NKEYS    = ROWS * COLS;
    localparam int QUAL_CYC = TICK_CYCLES * QUAL_TICKS;
    localparam int CW       = $clog2(COLS);
    localparam int RW       = $clog2(ROWS);
    localparam int KIW      = 7;
    localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);
    localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);

    kpd_state_e         state, nxt;
    logic [CW-1:0]      col_idx;
    logic [RW-1:0]      er;
    logic [CW-1:0]      ec;
    logic [NKEYS-1:0]   cur, prev, deb;
    logic [KIW-1:0]     emit_k;
    logic               wake, col_last, emit_last, qual_done, timer_clr;
    logic               frame_stable, frame_open;

    assign wake         = |(row_en & ~row_in);
    assign col_last     = (col_idx == COL_MAX);
    assign emit_last    = (er == ROW_MAX) && (ec == COL_MAX);
    assign emit_k       = KIW'(er) * KIW'(COLS) + KIW'(ec);
    assign frame_stable = (cur == prev);
    assign frame_open   = (cur == '0);
    assign timer_clr    = (state == ST_IDLE) || (state == ST_FRAME && !frame_stable);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (wake) nxt = ST_DRIVE;
            ST_DRIVE:  if (col_en[col_idx]) nxt = ST_SAMPLE;
                       else if (col_last)   nxt = ST_FRAME;
            ST_SAMPLE: nxt = col_last ? ST_FRAME : ST_DRIVE;
            ST_FRAME:  if (frame_stable && qual_done && cur != deb) nxt = ST_EMIT;
                       else if (frame_open && deb == '0)           nxt = ST_IDLE;
                       else                                        nxt = ST_DRIVE;
            ST_EMIT:   if (emit_last) nxt = frame_open ? ST_IDLE : ST_DRIVE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // datapath and event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_idx  <= '0;
            er       <= '0;
            ec       <= '0;
            cur      <= '0;
            prev     <= '0;
            deb      <= '0;
            evt_push <= 1'b0;
            evt_code <= '0;
        end else begin
            evt_push <= 1'b0;
            unique case (state)
                ST_IDLE: col_idx <= '0;
                ST_DRIVE: begin
                    if (!col_en[col_idx]) begin
                        for (int r = 0; r < ROWS; r++)
                            cur[KIW'(r * COLS) + KIW'(col_idx)] <= 1'b0;
                        col_idx <= col_last ? '0 : col_idx + 1'b1;
                    end
                end
                ST_SAMPLE: begin
                    for (int r = 0; r < ROWS; r++)
                        cur[KIW'(r * COLS) + KIW'(col_idx)] <= row_en[r] & ~row_in[r];
                    col_idx <= col_last ? '0 : col_idx + 1'b1;
                end
                ST_FRAME: begin
                    if (!frame_stable) prev <= cur;
                    er      <= '0;
                    ec      <= '0;
                    col_idx <= '0;
                end
                ST_EMIT: begin
                    if (cur[emit_k] != deb[emit_k]) begin
                        deb[emit_k] <= cur[emit_k];
                        evt_push    <= 1'b1;
                        evt_code    <= {cur[emit_k], emit_k + 7'd1};
                    end
                    if (er == ROW_MAX) begin
                        er <= '0;
                        ec <= (ec == COL_MAX) ? '0 : ec + 1'b1;
                    end else begin
                        er <= er + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    kpd_qual_timer #(.LIMIT(QUAL_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .done  (qual_done)
    );

    kpd_col_drive #(.COLS(COLS)) u_drive (
        .clk           (clk),
        .rst_n         (rst_n),
        .state         (state),
        .col_idx       (col_idx),
        .col_en        (col_en),
        .col_drive_low (col_drive_low)
    );

    kpd_irq_status u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (evt_push),
        .clr    (status_clr),
        .en     (irq_en),
        .status (ke_status),
        .irq    (irq_req)
    );

    AST_DRIVE_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (col_drive_low & ~col_en) == '0); // R2
    AST_EMIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT) |-> qual_done); // R4
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_push |-> (evt_code[6:0] >= 7'd1 && evt_code[6:0] <= 7'(NKEYS))); // R5
    AST_IDLE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (deb == '0)); // R9
endmodule

// File: tb/kpd_matrix_scan_bench.sv
module kpd_matrix_scan_bench;
    localparam int ROWS = 8;
    localparam int COLS = 10;
    localparam int TICK = 4;
    localparam int QT   = 25;
    localparam int QUAL = TICK * QT;
    localparam int WDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ROWS-1:0] row_en;
    logic [COLS-1:0] col_en;
    logic [ROWS-1:0] row_in;
    logic [COLS-1:0] col_drive_low;
    logic irq_en, status_clr, evt_push, ke_status, irq_req;
    logic [7:0] evt_code;
    logic [ROWS-1:0][COLS-1:0] keys;

    int checks = 0, failures = 0, cyc = 0, ev_cnt = 0, drive_viol = 0;
    logic [7:0] ev_code [0:31];
    int         ev_cyc  [0:31];

    always #4ns clk = ~clk;

    kpd_matrix_scan #(.ROWS(ROWS), .COLS(COLS), .TICK_CYCLES(TICK), .QUAL_TICKS(QT))
    u_kpd_matrix_scan (
        .clk(clk), .rst_n(rst_n), .row_en(row_en), .col_en(col_en), .row_in(row_in),
        .col_drive_low(col_drive_low), .irq_en(irq_en), .status_clr(status_clr),
        .evt_push(evt_push), .evt_code(evt_code), .ke_status(ke_status), .irq_req(irq_req)
    );

    // matrix model: a row reads low when a held key joins it to a driven column
    always_comb
        for (int r = 0; r < ROWS; r++) row_in[r] = ~|(keys[r] & col_drive_low);

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (evt_push && ev_cnt < 32) begin
                ev_code[ev_cnt] = evt_code;
                ev_cyc[ev_cnt]  = cyc;
                ev_cnt = ev_cnt + 1;
            end
            if ((col_drive_low & ~col_en) != 0 ||
                (col_drive_low != col_en && !$onehot0(col_drive_low)))
                drive_viol = drive_viol + 1;
        end
        if (cyc == WDOG) begin
            failures = failures + 1;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ev(input int n);
        int t = 0;
        while (ev_cnt < n && t < 3000) begin @(negedge clk); t++; end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_status();
        status_clr = 1'b1; @(negedge clk); status_clr = 1'b0; @(negedge clk);
    endtask

    initial begin
        int t0;
        int k;
        int exp_list [0:7];
        int n_exp;
        keys = '0; row_en = '1; col_en = '1; irq_en = 1'b1; status_clr = 1'b0;
        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(2);

        // R1: reset state
        chk(col_drive_low == col_en, "R1 idle drive after reset", int'(col_drive_low), int'(col_en));
        chk(ke_status == 1'b0 && irq_req == 1'b0, "R1 status clear", int'(ke_status), 0);
        idle_cycles(20);
        chk(ev_cnt == 0, "R1 no event after reset", ev_cnt, 0);

        // sweep every key: press, release, return to idle
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                k = r * COLS + c + 1;
                ev_cnt = 0;
                keys[r][c] = 1'b1; t0 = cyc;
                wait_ev(1);
                chk(ev_cnt == 1, "R5 press event count", ev_cnt, 1);
                chk(ev_code[0] == 8'(128 + k), "R5 press code", int'(ev_code[0]), 128 + k);
                chk(ev_cyc[0] - t0 >= QUAL, "R4 press qualification", ev_cyc[0] - t0, QUAL);
                idle_cycles(2);
                chk(ke_status == 1'b1 && irq_req == 1'b1, "R8 status and irq set", int'(irq_req), 1);
                clr_status();
                chk(ke_status == 1'b0, "R8 status cleared", int'(ke_status), 0);
                keys[r][c] = 1'b0; t0 = cyc;
                wait_ev(2);
                chk(ev_cnt == 2 && ev_code[1] == 8'(k), "R6 release code", int'(ev_code[1]), k);
                chk(ev_cyc[1] - t0 >= QUAL, "R4 release qualification", ev_cyc[1] - t0, QUAL);
                idle_cycles(120);
                chk(col_drive_low == col_en, "R9 back to idle", int'(col_drive_low), int'(col_en));
                chk(ev_cnt == 2, "R6 single release", ev_cnt, 2);
                clr_status();
            end
        end

        // R7: simultaneous keys emitted column-major
        ev_cnt = 0;
        keys[2][7] = 1'b1; keys[5][1] = 1'b1; keys[0][7] = 1'b1;
        n_exp = 0;
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++)
                if (keys[r][c]) begin exp_list[n_exp] = r * COLS + c + 1; n_exp++; end
        wait_ev(3);
        for (int i = 0; i < 3; i++)
            chk(ev_code[i] == 8'(128 + exp_list[i]), "R7 press order", int'(ev_code[i]), 128 + exp_list[i]);
        keys = '0;
        wait_ev(6);
        for (int i = 0; i < 3; i++)
            chk(ev_code[3 + i] == 8'(exp_list[i]), "R7 release order", int'(ev_code[3 + i]), exp_list[i]);
        idle_cycles(150);
        clr_status();

        // R4: a short press yields nothing
        ev_cnt = 0;
        keys[3][3] = 1'b1; idle_cycles(QUAL / 3); keys[3][3] = 1'b0;
        idle_cycles(4 * QUAL);
        chk(ev_cnt == 0, "R4 short press ignored", ev_cnt, 0);
        chk(col_drive_low == col_en, "R9 idle after glitch", int'(col_drive_low), int'(col_en));

        // R2/R3: disabled column 3 and disabled row 6
        col_en[3] = 1'b0; row_en[6] = 1'b0;
        idle_cycles(2);
        chk(col_drive_low[3] == 1'b0, "R2 disabled column released", int'(col_drive_low[3]), 0);
        ev_cnt = 0;
        keys[1][3] = 1'b1; idle_cycles(4 * QUAL);
        chk(ev_cnt == 0, "R3 key in disabled column ignored", ev_cnt, 0);
        keys[1][3] = 1'b0; keys[6][0] = 1'b1; idle_cycles(4 * QUAL);
        chk(ev_cnt == 0, "R3 key in disabled row ignored", ev_cnt, 0);
        keys[6][0] = 1'b0; idle_cycles(4 * QUAL);
        keys[1][4] = 1'b1;
        wait_ev(1);
        chk(ev_code[0] == 8'(128 + 15), "R3 enabled key still reported", int'(ev_code[0]), 143);
        keys[1][4] = 1'b0;
        wait_ev(2);
        idle_cycles(150);
        chk(col_drive_low == col_en, "R9 idle with partial masks", int'(col_drive_low), int'(col_en));
        clr_status();
        col_en = '1; row_en = '1;

        // R8: interrupt masked
        irq_en = 1'b0; ev_cnt = 0;
        keys[7][9] = 1'b1;
        wait_ev(1);
        chk(ev_code[0] == 8'(128 + 80), "R5 last key code", int'(ev_code[0]), 208);
        idle_cycles(2);
        chk(ke_status == 1'b1 && irq_req == 1'b0, "R8 irq masked", int'(irq_req), 0);
        irq_en = 1'b1; #1ns;
        chk(irq_req == 1'b1, "R8 irq unmasked", int'(irq_req), 1);
        keys[7][9] = 1'b0;
        wait_ev(2);
        idle_cycles(150);
        clr_status();

        chk(drive_viol == 0, "R3 one column at a time / R2 enabled only", drive_viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule